// File: doc/BRIEF.md
# Power control register with failsafe countdown

This block is an 8-bit control register for an always-powered power-management domain. Most of its bits are not storage. Writing a 1 to one of them issues a command, and the bit always reads back as 0. The commands start, stop or reload a switch-off countdown, force the power-on output inactive, release a held power-on-reset, and clear a latched power-failure flag. Writing a 0 to a command bit does nothing.

The countdown is clocked by a slow tick input, nominally one pulse per second. When the count reaches zero, the block sends a one-cycle request to turn the power-on output off. The same request also follows a software-off command.

The block also drives a power-on-reset output, in one of two modes. In pulse mode, a request produces a pulse of fixed length. In level mode, the output stays asserted until software releases it. The register is cleared only by the supply-first power-up reset. The system master reset does not reach it.

Top module: `pwrctl_reg`

## Requirements
- R1: After power-up reset, `rd_data` reads 0x00 and `por_out` and `pwr_off_req` are low.
- R2: Bit 1 (countdown length), bit 2 (reset mode) and bit 4 (a plain storage bit) keep the value last written and read back in place. Bits 0, 3, 5 and 6 always read 0.
- R3: A write with bit 0 set loads the countdown from that same write's bit 1: TICKS_SHORT ticks when bit 1 is 0, TICKS_LONG when it is 1. `pwr_off_req` pulses high for one cycle in the cycle after the edge that samples the last tick of the count.
- R4: A write with bit 6 set stops the countdown and zeroes it, and no expiry follows. If bits 6 and 0 are set in the same write, the stop wins.
- R5: A trigger write while the countdown is running reloads the full length. A write with bit 0 clear leaves a running countdown untouched.
- R6: A write with bit 5 set raises `pwr_off_req` for exactly one cycle, in the cycle after the write edge.
- R7: Bit 7 is set by a `batt_switch` pulse and stays set until a write with bit 7 at 1 clears it. Writing 0 to bit 7 has no effect. If a set and a clear arrive in the same cycle, the set wins.
- R8: In pulse mode (bit 2 = 0), a `por_trig` pulse makes `por_out` high for exactly POR_PULSE cycles, starting in the cycle after the trigger edge.
- R9: In level mode (bit 2 = 1), a `por_trig` pulse holds `por_out` high until a write with bit 3 set. `por_out` goes low in the cycle after that write.
- R10: A write of 0x00 produces no `pwr_off_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on domain clock |
| rst | input | 1 | Supply-first power-up reset, synchronous, active high |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data; command bits read 0 |
| tick | input | 1 | One-cycle time-base pulse (nominally 1 Hz) |
| batt_switch | input | 1 | One-cycle pulse when supply moves from main to battery |
| por_trig | input | 1 | One-cycle request to assert power-on reset |
| pwr_off_req | output | 1 | One-cycle request to turn the power-on output off |
| por_out | output | 1 | Power-on-reset output |

## Verification
The bench builds the block with TICKS_SHORT=3, TICKS_LONG=6 and POR_PULSE=4. These values let it count every tick of both countdown lengths and watch every cycle of a pulse-mode reset within a short run. With lengths that small, the bench can also test retriggering partway through a count, stop-versus-trigger in the same write, and countdowns of random length, and count ticks to the exact expiry point.

// File: rtl/pwrctl_pkg.sv
package pwrctl_pkg;

    localparam int BIT_TRIG   = 0;
    localparam int BIT_LEN    = 1;
    localparam int BIT_PLVL   = 2;
    localparam int BIT_PCLR   = 3;
    localparam int BIT_SPARE  = 4;
    localparam int BIT_SOFF   = 5;
    localparam int BIT_STOP   = 6;
    localparam int BIT_PFAIL  = 7;

    typedef struct packed {
        logic fs_trig;
        logic fs_stop;
        logic len_long;
        logic por_clr;
        logic soft_off;
        logic pf_clr;
    } cmd_t;

    typedef struct packed {
        logic len_long;
        logic por_level;
        logic spare;
        logic pf;
    } cfg_t;

    function automatic cmd_t decode_cmd(input logic we, input logic [7:0] d);
        cmd_t c;
        c.fs_trig  = we & d[BIT_TRIG];
        c.fs_stop  = we & d[BIT_STOP];
        c.len_long = d[BIT_LEN];
        c.por_clr  = we & d[BIT_PCLR];
        c.soft_off = we & d[BIT_SOFF];
        c.pf_clr   = we & d[BIT_PFAIL];
        return c;
    endfunction

    function automatic logic [7:0] pack_rd(input cfg_t c);
        logic [7:0] r;
        r            = '0;
        r[BIT_LEN]   = c.len_long;
        r[BIT_PLVL]  = c.por_level;
        r[BIT_SPARE] = c.spare;
        r[BIT_PFAIL] = c.pf;
        return r;
    endfunction

endpackage

// File: rtl/pwrctl_failsafe.sv
module pwrctl_failsafe #(
    parameter int TICKS_SHORT = 5,
    parameter int TICKS_LONG  = 21
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    input  logic stop,
    input  logic len_long,
    input  logic tick,
    output logic expire
);
    localparam int CW = $clog2(TICKS_LONG + 1);

    logic [CW-1:0] cnt;
    logic          run;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            run    <= 1'b0;
            expire <= 1'b0;
        end else begin
            expire <= 1'b0;
            if (stop) begin
                cnt <= '0;
                run <= 1'b0;
            end else if (trig) begin
                cnt <= len_long ? CW'(TICKS_LONG) : CW'(TICKS_SHORT);
                run <= 1'b1;
            end else if (run && tick) begin
                if (cnt == CW'(1)) begin
                    cnt    <= '0;
                    run    <= 1'b0;
                    expire <= 1'b1;
                end else begin
                    cnt <= cnt - CW'(1);
                end
            end
        end
    end

    AST_FS_STOP_WINS: assert property (@(posedge clk) disable iff (rst)
        stop |=> (!run && cnt == '0 && !expire)); // R4
    AST_FS_TRIG_RUNS: assert property (@(posedge clk) disable iff (rst)
        (trig && !stop) |=> run); // R5
    AST_FS_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(TICKS_LONG)); // R3
    AST_FS_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !run |-> cnt == '0); // R4

endmodule

// File: rtl/pwrctl_por.sv
module pwrctl_por #(
    parameter int PULSE_LEN = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    input  logic level_mode,
    input  logic clr,
    output logic por
);
    localparam int CW = $clog2(PULSE_LEN + 1);

    logic [CW-1:0] pcnt;
    logic          held;

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt <= '0;
            held <= 1'b0;
        end else begin
            if (trig && !level_mode)
                pcnt <= CW'(PULSE_LEN);
            else if (pcnt != '0)
                pcnt <= pcnt - CW'(1);

            if (trig && level_mode)
                held <= 1'b1;
            else if (clr)
                held <= 1'b0;
        end
    end

    assign por = held | (pcnt != '0);

    AST_POR_HELD: assert property (@(posedge clk) disable iff (rst)
        (held && !clr) |=> held); // R9
    AST_POR_PULSE_RANGE: assert property (@(posedge clk) disable iff (rst)
        pcnt <= CW'(PULSE_LEN)); // R8
    AST_POR_PULSE_START: assert property (@(posedge clk) disable iff (rst)
        (trig && !level_mode) |=> por); // R8

endmodule

// File: rtl/pwrctl_reg.sv
module pwrctl_reg
    import pwrctl_pkg::*;
#(
    parameter int TICKS_SHORT = 5,
    parameter int TICKS_LONG  = 21,
    parameter int POR_PULSE   = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       tick,
    input  logic       batt_switch,
    input  logic       por_trig,
    output logic       pwr_off_req,
    output logic       por_out
);
    cmd_t cmd;
    cfg_t cfg;
    logic soft_off_q;
    logic fs_expire;

    assign cmd = decode_cmd(wr_en, wr_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg        <= '0;
            soft_off_q <= 1'b0;
        end else begin
            soft_off_q <= cmd.soft_off;
            if (wr_en) begin
                cfg.len_long  <= wr_data[BIT_LEN];
                cfg.por_level <= wr_data[BIT_PLVL];
                cfg.spare     <= wr_data[BIT_SPARE];
            end
            if (batt_switch)
                cfg.pf <= 1'b1;
            else if (cmd.pf_clr)
                cfg.pf <= 1'b0;
        end
    end

    assign rd_data     = pack_rd(cfg);
    assign pwr_off_req = soft_off_q | fs_expire;

    pwrctl_failsafe #(
        .TICKS_SHORT (TICKS_SHORT),
        .TICKS_LONG  (TICKS_LONG)
    ) u_failsafe (
        .clk      (clk),
        .rst      (rst),
        .trig     (cmd.fs_trig),
        .stop     (cmd.fs_stop),
        .len_long (cmd.len_long),
        .tick     (tick),
        .expire   (fs_expire)
    );

    pwrctl_por #(
        .PULSE_LEN (POR_PULSE)
    ) u_por (
        .clk        (clk),
        .rst        (rst),
        .trig       (por_trig),
        .level_mode (cfg.por_level),
        .clr        (cmd.por_clr),
        .por        (por_out)
    );

    AST_PF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (rd_data[BIT_PFAIL] && !(wr_en && wr_data[BIT_PFAIL])) |=> rd_data[BIT_PFAIL]); // R7
    AST_PF_SET: assert property (@(posedge clk) disable iff (rst)
        batt_switch |=> rd_data[BIT_PFAIL]); // R7
    AST_SOFT_OFF: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[BIT_SOFF]) |=> pwr_off_req); // R6

endmodule

// File: tb/pwrctl_reg_bench.sv
module pwrctl_reg_bench;
    localparam int CLK_PERIOD = 10;
    localparam int T_SHORT = 3;
    localparam int T_LONG  = 6;
    localparam int P_LEN   = 4;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic       tick;
    logic       batt_switch;
    logic       por_trig;
    logic       pwr_off_req;
    logic       por_out;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwrctl_reg #(.TICKS_SHORT(T_SHORT), .TICKS_LONG(T_LONG), .POR_PULSE(P_LEN)) u_pwrctl_reg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .tick(tick), .batt_switch(batt_switch), .por_trig(por_trig),
        .pwr_off_req(pwr_off_req), .por_out(por_out)
    );

    function automatic logic [7:0] exp_rd(input logic [7:0] d, input logic pf);
        return {pf, 3'b000, d[4], 1'b0, d[2], d[1], 1'b0} & 8'b1001_0110 | {pf, 7'b0};
    endfunction

    function automatic int exp_len(input logic sel);
        return sel ? T_LONG : T_SHORT;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic tick_once();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=<100000", cycles);
            report();
        end
    end

    initial begin
        int n;
        logic [7:0] d;
        void'($urandom(32'd1234));
        rst = 1'b1; wr_en = 1'b0; wr_data = '0; tick = 1'b0;
        batt_switch = 1'b0; por_trig = 1'b0;
        cyc(3);
        rst = 1'b0;
        cyc(1);
        // R1 reset state
        chk("R1 rd_data", rd_data, 0);
        chk("R1 por_out", por_out, 0);
        chk("R1 pwr_off_req", pwr_off_req, 0);

        // R2 read-back with command bits set
        wr(8'h7F);
        chk("R2 readback 0x7F", rd_data, 8'h16);
        cyc(T_LONG + 2);
        wr(8'h00);
        chk("R2 readback 0x00", rd_data, 8'h00);

        // R10 zero write produces no off request
        chk("R10 no off on zero write", pwr_off_req, 0);

        // R3 short and long countdowns
        for (int s = 0; s < 2; s++) begin
            wr(s ? 8'h03 : 8'h01);
            for (int k = 1; k <= exp_len(s[0]); k++) begin
                tick_once();
                chk(s ? "R3 long expiry" : "R3 short expiry", pwr_off_req, (k == exp_len(s[0])) ? 1 : 0);
            end
            cyc(1);
            chk("R3 expiry one cycle", pwr_off_req, 0);
        end

        // R4 stop halts countdown
        wr(8'h01);
        tick_once();
        wr(8'h40);
        n = 0;
        for (int k = 0; k < T_LONG + 2; k++) begin tick_once(); n += pwr_off_req; end
        chk("R4 no expiry after stop", n, 0);
        // R4 stop and trigger together
        wr(8'h41);
        n = 0;
        for (int k = 0; k < T_LONG + 2; k++) begin tick_once(); n += pwr_off_req; end
        chk("R4 stop wins over trigger", n, 0);

        // R5 retrigger reloads
        wr(8'h01);
        tick_once(); tick_once();
        wr(8'h01);
        tick_once(); tick_once();
        chk("R5 no early expiry after reload", pwr_off_req, 0);
        tick_once();
        chk("R5 expiry after full reload", pwr_off_req, 1);
        // R5 non-trigger write leaves count alone
        wr(8'h01);
        tick_once();
        wr(8'h02);
        tick_once();
        chk("R5 count unaffected", pwr_off_req, 0);
        tick_once();
        chk("R5 expiry keeps original length", pwr_off_req, 1);

        // R6 software off
        wr(8'h20);
        chk("R6 off pulse", pwr_off_req, 1);
        cyc(1);
        chk("R6 off pulse one cycle", pwr_off_req, 0);

        // R7 power-fail flag
        @(negedge clk); batt_switch = 1'b1;
        @(negedge clk); batt_switch = 1'b0;
        chk("R7 flag set", rd_data[7], 1);
        wr(8'h00);
        chk("R7 write 0 keeps flag", rd_data[7], 1);
        wr(8'h80);
        chk("R7 write 1 clears flag", rd_data[7], 0);
        @(negedge clk); batt_switch = 1'b1; wr_en = 1'b1; wr_data = 8'h80;
        @(negedge clk); batt_switch = 1'b0; wr_en = 1'b0; wr_data = '0;
        chk("R7 set wins over clear", rd_data[7], 1);
        wr(8'h80);

        // R8 pulse-mode reset
        @(negedge clk); por_trig = 1'b1;
        @(negedge clk); por_trig = 1'b0;
        n = 0;
        for (int k = 0; k < P_LEN + 3; k++) begin n += por_out; @(negedge clk); end
        chk("R8 pulse length", n, P_LEN);
        wr(8'h08);
        chk("R8 clear in pulse mode idle", por_out, 0);

        // R9 level-mode reset
        wr(8'h04);
        @(negedge clk); por_trig = 1'b1;
        @(negedge clk); por_trig = 1'b0;
        cyc(P_LEN + 10);
        chk("R9 level held", por_out, 1);
        wr(8'h04);
        chk("R9 held without clear", por_out, 1);
        wr(8'h0C);
        chk("R9 released by clear", por_out, 0);

        // R2 random read-back (bit 7 zero, flag clear)
        for (int i = 0; i < 30; i++) begin
            d = 8'($urandom) & 8'h1E;
            wr(d);
            chk("R2 random readback", rd_data, exp_rd(d, 1'b0));
        end
        wr(8'h40);

        // R3 random countdown lengths
        for (int i = 0; i < 6; i++) begin
            d = 8'($urandom) & 8'h02;
            wr(d | 8'h01);
            n = 0;
            for (int k = 1; k <= T_LONG + 3; k++) begin
                tick_once();
                if (pwr_off_req && n == 0) n = k;
            end
            chk("R3 random length", n, exp_len(d[1]));
        end

        done = 1'b1;
        report();
    end
endmodule